// File: doc/BRIEF.md
# Pipelined Dual-Port Byte-Write RAM

A two-port synchronous static memory in which either port may read or write any word at any time, including the word the other port is using. Each word holds 36 bits organised as four 9-bit byte lanes, and every access carries a per-lane active-low enable. All requests are captured on the rising clock edge. A write updates only the enabled lanes. A read returns the word one cycle after its address was captured. Its lane-drive bits show which lanes would be driven onto a shared bus, and they are set by the controls of the cycle that issued the read.

A port is selected only when its low-true chip enable is low and its high-true chip enable is high. Each port carries a small wake-up state machine, because a port that has just been deselected must see two consecutive selected edges before its outputs drive again. The states are ST_OFF, ST_WAKE and ST_ON. Any unselected edge moves the machine to ST_OFF, and reset also leaves it there. A selected edge moves ST_OFF to ST_WAKE, ST_WAKE to ST_ON, and holds ST_ON. A read captured while the machine is in ST_OFF never drives. The asynchronous output enable can force every lane to float at any moment, and it does not disturb the pipeline. A real tristate bus is replaced by a data value plus one drive bit per lane. When both ports write the same lane of the same word on the same edge, the port named by the `A_WINS` parameter wins. Both ports share one clock.

Top module: `dual_port_byte_ram`

## Requirements
- R1: A word is 36 bits in four 9-bit lanes, with lane l at bits 9l+8 down to 9l. Bit l of a port's `*_lane_n` enables lane l when low.
- R2: A port is selected at an edge only if `*_sel_n` is 0 and `*_sel` is 1. An unselected request writes nothing, and its read slot drives no lane.
- R3: A selected write (`*_rd_wr_n` = 0) changes exactly the enabled lanes of the addressed word. All other lanes keep their contents.
- R4: A selected read raises `*_lane_drv` bit l only for lanes whose enable bit was 0 in that request. A write cycle leaves all drive bits at 0 in its result slot.
- R5: Read data and drive bits for a request captured at edge k appear after edge k+1. After edge k they still show the previous result.
- R6: After reset or after any unselected edge, a read captured at the first selected edge drives nothing. A read captured at the second consecutive selected edge drives normally.
- R7: While `*_out_en_n` is 1, all drive bits of that port are 0 at once, without any clock edge. Returning it to 0 restores the registered drive state.
- R8: Repeated reads of one address return the same value on every following clock.
- R9: A read on one port captured at the same edge as a write to the same word by the other port returns the old content. A read captured one edge later returns the new content.
- R10: When both ports write the same word at one edge, lanes enabled by only one port take that port's data. Lanes enabled by both take port A's data when `A_WINS` = 1, the default.
- R11: After reset both ports drive no lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset of pipeline and wake-up state |
| a_sel_n | input | 1 | Port A chip enable, active low |
| a_sel | input | 1 | Port A chip enable, active high |
| a_rd_wr_n | input | 1 | Port A access type: 1 read, 0 write |
| a_lane_n | input | 4 | Port A per-lane enables, active low |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | 36 | Port A write data |
| a_out_en_n | input | 1 | Port A asynchronous output enable, active low |
| a_rdata | output | 36 | Port A read data |
| a_lane_drv | output | 4 | Port A per-lane drive indication |
| b_sel_n | input | 1 | Port B chip enable, active low |
| b_sel | input | 1 | Port B chip enable, active high |
| b_rd_wr_n | input | 1 | Port B access type: 1 read, 0 write |
| b_lane_n | input | 4 | Port B per-lane enables, active low |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | 36 | Port B write data |
| b_out_en_n | input | 1 | Port B asynchronous output enable, active low |
| b_rdata | output | 36 | Port B read data |
| b_lane_drv | output | 4 | Port B per-lane drive indication |

## Verification
Two functions can meet in one cycle. One is a write on one port and a read of the same word on the other port. The other is two writes to one word, one from each port. The bench provokes the first by presenting port A's write and port B's read before the same edge. It judges the result by B returning the old word and then, on a read one edge later, the new word. The bench provokes the second by giving the ports overlapping and disjoint lane enables on the same edge. It judges the merged word lane by lane against the priority rule.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAKE = 2'd1,
        ST_ON   = 2'd2
    } wake_e;
endpackage

// File: rtl/dpr_lane_bank.sv
module dpr_lane_bank
    import dpr_pkg::*;
#(
    parameter int AW     = 8,
    parameter bit A_WINS = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_we,
    input  logic [AW-1:0]     a_addr,
    input  logic [LANE_W-1:0] a_d,
    output logic [LANE_W-1:0] a_q,
    input  logic              b_we,
    input  logic [AW-1:0]     b_addr,
    input  logic [LANE_W-1:0] b_d,
    output logic [LANE_W-1:0] b_q
);
    localparam int DEPTH = 1 << AW;

    logic [LANE_W-1:0] mem [DEPTH];

    // The later non-blocking assignment wins when both hit one word.
    generate
        if (A_WINS) begin : g_a_last
            always_ff @(posedge clk) begin
                if (b_we) mem[b_addr] <= b_d;
                if (a_we) mem[a_addr] <= a_d;
            end
        end else begin : g_b_last
            always_ff @(posedge clk) begin
                if (a_we) mem[a_addr] <= a_d;
                if (b_we) mem[b_addr] <= b_d;
            end
        end
    endgenerate

    assign a_q = mem[a_addr];
    assign b_q = mem[b_addr];

    AST_A_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (a_we && (A_WINS || !(b_we && (b_addr == a_addr))))
        |=> (mem[$past(a_addr)] == $past(a_d))); // R3
    AST_B_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (b_we && (!A_WINS || !(a_we && (a_addr == b_addr))))
        |=> (mem[$past(b_addr)] == $past(b_d))); // R10
endmodule

// File: rtl/dpr_port_pipe.sv
module dpr_port_pipe
    import dpr_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              sel,
    input  logic              rd_wr_n,
    input  logic [LANES-1:0]  lane_n,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              out_en_n,
    input  logic [WORD_W-1:0] mem_q,
    output logic [LANES-1:0]  wr_lane,
    output logic [AW-1:0]     acc_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rdata,
    output logic [LANES-1:0]  lane_drv
);
    logic port_on;
    assign port_on = !sel_n && sel;

    wake_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = ST_OFF;
        if (port_on) begin
            unique case (st_q)
                ST_OFF:  st_d = ST_WAKE;
                ST_WAKE: st_d = ST_ON;
                ST_ON:   st_d = ST_ON;
                default: st_d = ST_OFF;
            endcase
        end
    end

    logic              s1_on, s1_rd, s1_armed;
    logic [LANES-1:0]  s1_lane_n;
    logic [AW-1:0]     s1_addr;
    logic [WORD_W-1:0] s1_wdata;
    logic [WORD_W-1:0] q_data;
    logic [LANES-1:0]  q_drv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_on     <= 1'b0;
            s1_rd     <= 1'b1;
            s1_armed  <= 1'b0;
            s1_lane_n <= '1;
            s1_addr   <= '0;
            s1_wdata  <= '0;
            q_data    <= '0;
            q_drv     <= '0;
        end else begin
            s1_on     <= port_on;
            s1_rd     <= rd_wr_n;
            s1_armed  <= port_on && (st_q != ST_OFF);
            s1_lane_n <= lane_n;
            s1_addr   <= addr;
            s1_wdata  <= wdata;
            q_data    <= mem_q;
            q_drv     <= (s1_armed && s1_rd) ? ~s1_lane_n : '0;
        end
    end

    assign wr_lane  = (s1_on && !s1_rd) ? ~s1_lane_n : '0;
    assign acc_addr = s1_addr;
    assign wr_data  = s1_wdata;
    assign rdata    = q_data;
    assign lane_drv = out_en_n ? '0 : q_drv;

    AST_DESEL_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        !port_on |=> ##1 (q_drv == '0)); // R2
    AST_WAKE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OFF) |=> ##1 (q_drv == '0)); // R6
    AST_WRITE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (port_on && !rd_wr_n) |=> ##1 (q_drv == '0)); // R4
    AST_ON_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_ON) && port_on && rd_wr_n && (lane_n != '1)) |=> ##1 (q_drv != '0)); // R6
    AST_STAGE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q_drv & $past(s1_lane_n)) == '0)); // R4
endmodule

// File: rtl/dual_port_byte_ram.sv
module dual_port_byte_ram
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter bit A_WINS = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_sel_n,
    input  logic              a_sel,
    input  logic              a_rd_wr_n,
    input  logic [LANES-1:0]  a_lane_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [WORD_W-1:0] a_wdata,
    input  logic              a_out_en_n,
    output logic [WORD_W-1:0] a_rdata,
    output logic [LANES-1:0]  a_lane_drv,
    input  logic              b_sel_n,
    input  logic              b_sel,
    input  logic              b_rd_wr_n,
    input  logic [LANES-1:0]  b_lane_n,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [WORD_W-1:0] b_wdata,
    input  logic              b_out_en_n,
    output logic [WORD_W-1:0] b_rdata,
    output logic [LANES-1:0]  b_lane_drv
);
    logic [LANES-1:0]  a_wl, b_wl;
    logic [ADDR_W-1:0] a_acc, b_acc;
    logic [WORD_W-1:0] a_wd, b_wd, a_mq, b_mq;

    dpr_port_pipe #(.AW(ADDR_W)) u_port_a (
        .clk(clk), .rst_n(rst_n), .sel_n(a_sel_n), .sel(a_sel),
        .rd_wr_n(a_rd_wr_n), .lane_n(a_lane_n), .addr(a_addr),
        .wdata(a_wdata), .out_en_n(a_out_en_n), .mem_q(a_mq),
        .wr_lane(a_wl), .acc_addr(a_acc), .wr_data(a_wd),
        .rdata(a_rdata), .lane_drv(a_lane_drv)
    );

    dpr_port_pipe #(.AW(ADDR_W)) u_port_b (
        .clk(clk), .rst_n(rst_n), .sel_n(b_sel_n), .sel(b_sel),
        .rd_wr_n(b_rd_wr_n), .lane_n(b_lane_n), .addr(b_addr),
        .wdata(b_wdata), .out_en_n(b_out_en_n), .mem_q(b_mq),
        .wr_lane(b_wl), .acc_addr(b_acc), .wr_data(b_wd),
        .rdata(b_rdata), .lane_drv(b_lane_drv)
    );

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            dpr_lane_bank #(.AW(ADDR_W), .A_WINS(A_WINS)) u_bank (
                .clk(clk), .rst_n(rst_n),
                .a_we(a_wl[l]), .a_addr(a_acc),
                .a_d(a_wd[l*LANE_W +: LANE_W]), .a_q(a_mq[l*LANE_W +: LANE_W]),
                .b_we(b_wl[l]), .b_addr(b_acc),
                .b_d(b_wd[l*LANE_W +: LANE_W]), .b_q(b_mq[l*LANE_W +: LANE_W])
            );
        end
    endgenerate
endmodule

// File: tb/dual_port_byte_ram_tb.sv
module dual_port_byte_ram_tb_top;
    localparam int CLK_T = 10;
    localparam int AW    = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic a_sel_n, a_sel, a_rd_wr_n, a_out_en_n;
    logic b_sel_n, b_sel, b_rd_wr_n, b_out_en_n;
    logic [3:0]    a_lane_n, b_lane_n, a_lane_drv, b_lane_drv;
    logic [AW-1:0] a_addr, b_addr;
    logic [35:0]   a_wdata, b_wdata, a_rdata, b_rdata;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #(CLK_T/2) clk = ~clk;

    dual_port_byte_ram #(.ADDR_W(AW), .A_WINS(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_sel_n(a_sel_n), .a_sel(a_sel), .a_rd_wr_n(a_rd_wr_n), .a_lane_n(a_lane_n),
        .a_addr(a_addr), .a_wdata(a_wdata), .a_out_en_n(a_out_en_n),
        .a_rdata(a_rdata), .a_lane_drv(a_lane_drv),
        .b_sel_n(b_sel_n), .b_sel(b_sel), .b_rd_wr_n(b_rd_wr_n), .b_lane_n(b_lane_n),
        .b_addr(b_addr), .b_wdata(b_wdata), .b_out_en_n(b_out_en_n),
        .b_rdata(b_rdata), .b_lane_drv(b_lane_drv)
    );

    localparam logic [35:0] PARK = 36'h0_1111_1111;
    localparam logic [35:0] W0   = 36'h1_2345_6789;
    localparam logic [35:0] W1   = 36'hF_EDCB_A987;
    localparam logic [35:0] D9   = 36'h9_0F0F_3C3C;

    function automatic logic [35:0] merge(input logic [35:0] old, input logic [35:0] nw,
                                         input logic [3:0] ln);
        logic [35:0] r = old;
        for (int l = 0; l < 4; l++) if (!ln[l]) r[l*9 +: 9] = nw[l*9 +: 9];
        return r;
    endfunction

    function automatic logic [35:0] lmask(input logic [3:0] ln);
        return merge(36'h0, {36{1'b1}}, ln);
    endfunction

    task automatic step();
        @(posedge clk);
        #(CLK_T/2);
    endtask

    task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input bit p, input logic sn, input logic s, input logic rw,
                         input logic [3:0] ln, input logic [AW-1:0] ad, input logic [35:0] d);
        if (!p) begin
            a_sel_n = sn; a_sel = s; a_rd_wr_n = rw; a_lane_n = ln; a_addr = ad; a_wdata = d;
        end else begin
            b_sel_n = sn; b_sel = s; b_rd_wr_n = rw; b_lane_n = ln; b_addr = ad; b_wdata = d;
        end
    endtask

    task automatic idle(input bit p);
        drive(p, 1'b0, 1'b1, 1'b1, 4'hF, '0, '0);
    endtask

    task automatic wr(input bit p, input logic [AW-1:0] ad, input logic [3:0] ln,
                      input logic [35:0] d);
        drive(p, 1'b0, 1'b1, 1'b0, ln, ad, d);
        step();
        idle(p);
    endtask

    task automatic rd(input bit p, input logic [AW-1:0] ad, input logic [3:0] ln,
                      output logic [35:0] q, output logic [3:0] dv);
        drive(p, 1'b0, 1'b1, 1'b1, ln, ad, '0);
        step();
        idle(p);
        step();
        q  = p ? b_rdata : a_rdata;
        dv = p ? b_lane_drv : a_lane_drv;
    endtask

    task automatic t_reset();
        chk("R11 port A drive after reset", {32'h0, a_lane_drv}, 36'h0);
        chk("R11 port B drive after reset", {32'h0, b_lane_drv}, 36'h0);
    endtask

    task automatic t_wake();
        drive(1'b0, 1'b0, 1'b1, 1'b1, 4'h0, '0, '0);
        step();
        step();
        chk("R6 first selected read floats", {32'h0, a_lane_drv}, 36'h0);
        idle(1'b0);
        step();
        chk("R6 second selected read drives", {32'h0, a_lane_drv}, 36'hF);
        wr(1'b0, '0, 4'h0, PARK);
    endtask

    task automatic t_bytes();
        logic [35:0] q; logic [3:0] dv;
        wr(1'b0, 8'd5, 4'h0, W0);
        wr(1'b0, 8'd5, 4'b1011, W1);
        rd(1'b1, 8'd5, 4'h0, q, dv);
        chk("R3 lane 2 only write merged", q, merge(W0, W1, 4'b1011));
        chk("R1 full read drives four lanes", {32'h0, dv}, 36'hF);
        wr(1'b1, 8'd5, 4'b1110, W1);
        rd(1'b0, 8'd5, 4'h0, q, dv);
        chk("R1 lane 0 at bits 8..0", q, merge(merge(W0, W1, 4'b1011), W1, 4'b1110));
    endtask

    task automatic t_mask();
        logic [35:0] q; logic [3:0] dv;
        wr(1'b0, 8'd9, 4'h0, D9);
        rd(1'b0, 8'd9, 4'b1010, q, dv);
        chk("R4 drive only lanes 0 and 2", {32'h0, dv}, 36'h5);
        chk("R4 data on driven lanes", q & lmask(4'b1010), D9 & lmask(4'b1010));
        drive(1'b0, 1'b0, 1'b1, 1'b1, 4'h0, 8'd9, '0);
        step();
        drive(1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 8'd11, 36'h0);
        step();
        chk("R4 read slot before write drives", {32'h0, a_lane_drv}, 36'hF);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 4'h0, 8'd9, '0);
        step();
        chk("R4 write slot floats", {32'h0, a_lane_drv}, 36'h0);
        idle(1'b0);
        step();
        chk("R4 read slot after write drives", {32'h0, a_lane_drv}, 36'hF);
    endtask

    task automatic t_latency();
        logic [35:0] expw = merge(merge(W0, W1, 4'b1011), W1, 4'b1110);
        step();
        drive(1'b0, 1'b0, 1'b1, 1'b1, 4'h0, 8'd5, '0);
        step();
        chk("R5 one edge still previous result", a_rdata, PARK);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 4'h0, 8'd9, '0);
        step();
        chk("R5 data after second edge", a_rdata, expw);
        idle(1'b0);
        step();
        chk("R5 back to back read", a_rdata, D9);
    endtask

    task automatic t_hold_oe();
        drive(1'b0, 1'b0, 1'b1, 1'b1, 4'h0, 8'd9, '0);
        step();
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R8 held read value", a_rdata, D9);
        end
        a_out_en_n = 1'b1;
        #1;
        chk("R7 output enable high floats", {32'h0, a_lane_drv}, 36'h0);
        a_out_en_n = 1'b0;
        #1;
        chk("R7 output enable low restores", {32'h0, a_lane_drv}, 36'hF);
        idle(1'b0);
        step();
    endtask

    task automatic t_desel();
        logic [35:0] q; logic [3:0] dv;
        drive(1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 8'd9, 36'h0);
        step();
        drive(1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 8'd9, 36'h0);
        step();
        idle(1'b0);
        step();
        step();
        rd(1'b1, 8'd9, 4'h0, q, dv);
        chk("R2 deselected writes ignored", q, D9);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 4'h0, 8'd9, '0);
        step();
        idle(1'b1);
        step();
        chk("R2 deselected read floats", {32'h0, b_lane_drv}, 36'h0);
        rd(1'b1, 8'd9, 4'h0, q, dv);
        chk("R6 rearmed after two selected edges", {32'h0, dv}, 36'hF);
    endtask

    task automatic t_cross();
        logic [35:0] q; logic [3:0] dv;
        wr(1'b0, 8'd20, 4'h0, W0);
        drive(1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 8'd20, W1);
        drive(1'b1, 1'b0, 1'b1, 1'b1, 4'h0, 8'd20, '0);
        step();
        idle(1'b0);
        idle(1'b1);
        step();
        chk("R9 same-edge read returns old word", b_rdata, W0);
        rd(1'b1, 8'd20, 4'h0, q, dv);
        chk("R9 later read returns new word", q, W1);
    endtask

    task automatic t_collide();
        logic [35:0] q; logic [3:0] dv;
        drive(1'b0, 1'b0, 1'b1, 1'b0, 4'b0001, 8'd30, W1);
        drive(1'b1, 1'b0, 1'b1, 1'b0, 4'b1100, 8'd30, W0);
        step();
        idle(1'b0);
        idle(1'b1);
        rd(1'b0, 8'd30, 4'h0, q, dv);
        chk("R10 collision lanes merged with A priority",
            q, merge(merge(36'h0, W0, 4'b1100), W1, 4'b0001));
    endtask

    initial begin
        rst_n = 1'b0;
        a_out_en_n = 1'b0;
        b_out_en_n = 1'b0;
        idle(1'b0);
        idle(1'b1);
        #(CLK_T/2);
        step();
        step();
        rst_n = 1'b1;
        t_reset();
        t_wake();
        t_bytes();
        t_mask();
        t_latency();
        t_hold_oe();
        t_desel();
        t_cross();
        t_collide();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_T * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule